// File: doc/BRIEF.md
# Rate Gyro Power-Up Sequencer

This block brings a digital rate gyroscope from power-on to normal operation. After a start pulse it steps a serial frame engine through a fixed handshake. It waits a long settling delay and sends a sensor-data command with the self-check request set. It then sends three plain sensor-data commands, with two short gaps and one back-to-back issue. Last, it reads the fault register. Each reply is checked against a rule that belongs to its step.

The frame engine moves whole 32-bit words. The sequencer offers a command word with a valid/ready handshake. The engine later returns exactly one reply word with a one-cycle `rsp_valid` pulse. Delays are counted in clock cycles and derived from a clock-frequency parameter in kHz, so a small value gives short delays in simulation.

When the handshake ends, the block reports one of three outcomes: clean completion, completion with a non-fatal warning, or a fatal error. A fatal error also reports the step that failed. The captured fault field is always brought out. `hold_off` stays high, blocking other traffic to the sensor, until the sequence has completed without error.

Top module: `gyro_init_seq`

## Requirements
- R1: After reset the block is idle and issues no command until `start`. In that state `done`, `warn` and `err` are 0, `fail_step` and `fault_word` are 0, and `hold_off` is 1.
- R2: The first command word is 0x20000003: the sensor-data opcode in bit 29, the check request in bit 1, and odd parity in bit 0. `cmd_valid` rises LONG cycles after the edge that samples `start`, where LONG = CLK_KHZ*LONG_MS.
- R3: If the first reply is any value other than 0x00000001, `warn` is set and stays set. The sequence still continues.
- R4: The second command, 0x20000000, is offered SHORT cycles after the edge that takes the first reply, where SHORT = CLK_KHZ*SHORT_MS. Its reply is never examined.
- R5: The third command, 0x20000000, is offered SHORT cycles after the second reply. Its reply passes only if bits 7:0 OR 0x01 equal 0xFF and bits 27:26 equal 2'b10. Otherwise the block ends with `err` and `fail_step`=3.
- R6: The fourth command, 0x20000000, is offered on the cycle after the third reply is taken. The R5 rule applies to its reply, and a failure gives `fail_step`=4.
- R7: The fifth command, 0x80140000, is a read of register 0x0A: read opcode in bit 31, address in bits 24:17, odd parity in bit 0. It is offered on the cycle after the fourth reply. Bits 20:5 of its reply are latched on `fault_word`. If any of bits 11:0 of that field is set, the block ends with `err` and `fail_step`=5.
- R8: On success `done`=1, `err`=0, `fail_step`=0 and `hold_off`=0.
- R9: After a fatal error no further command is offered. `done`=1, `err`=1 and `hold_off` stays 1.
- R10: A `start` pulse at any time restarts from the long delay. On the next cycle `done`, `warn`, `err`, `fail_step` and `fault_word` are all cleared.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the command word is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts or restarts the sequence |
| cmd_valid | output | 1 | Command word offered to the frame engine |
| cmd_word | output | 32 | Command word |
| cmd_ready | input | 1 | Engine accepts the offered command |
| rsp_valid | input | 1 | One-cycle pulse: reply word present |
| rsp_word | input | 32 | Reply word for the last accepted command |
| hold_off | output | 1 | High until the sequence has completed without error |
| done | output | 1 | Sequence finished (success or error) |
| warn | output | 1 | First reply was not the expected value |
| err | output | 1 | Fatal check failure |
| fail_step | output | 3 | Step (3, 4 or 5) whose reply failed; 0 otherwise |
| fault_word | output | 16 | Bits 20:5 of the fault-register reply |

## Verification
The assertions watch on every cycle the rules that hold regardless of reply content. These are command stability under back-pressure, flags clearing after a start pulse, and the stickiness of `warn`. They also cover the silence and `hold_off` state after an error, and the legal range of `fail_step`. The delay lengths, the command word at each step, and the pass/fail decision for each reply word can only be shown by the bench's scenarios. Those scenarios drive good, corrupted and borderline replies (low byte 0xFE, fault bits above bit 11) and restart mid-sequence. They compare cycle counts and outcomes against values the bench computes itself.

// File: rtl/gis_pkg.sv
package gis_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_SEND,
    PH_RESP,
    PH_DONE,
    PH_FAIL
  } phase_t;

  typedef enum logic [1:0] {
    CK_FIRST,
    CK_IGNORE,
    CK_STATUS,
    CK_FAULT
  } check_t;

  localparam logic [WORD_W-1:0] OP_SENSOR   = 32'h2000_0000;
  localparam logic [WORD_W-1:0] OP_READ     = 32'h8000_0000;
  localparam logic [WORD_W-1:0] CHK_REQ     = 32'h0000_0002;
  localparam logic [WORD_W-1:0] FIRST_GOOD  = 32'h0000_0001;
  localparam logic [7:0]        FAULT_ADDR  = 8'h0A;
  localparam logic [15:0]       FAULT_MASK  = 16'h0FFF;
  localparam logic [1:0]        STATUS_GOOD = 2'b10;

  // Bit 0 is forced so that the whole word carries an odd number of ones.
  function automatic logic [WORD_W-1:0] with_odd_parity(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] base;
    base = w & ~32'h1;
    return (^base) ? base : (base | 32'h1);
  endfunction

  function automatic logic [WORD_W-1:0] sensor_cmd(input logic with_check);
    return with_odd_parity(OP_SENSOR | (with_check ? CHK_REQ : 32'h0));
  endfunction

  function automatic logic [WORD_W-1:0] read_cmd(input logic [7:0] addr);
    return with_odd_parity(OP_READ | ({24'h0, addr} << 17));
  endfunction

  function automatic logic reply_ok(input logic [WORD_W-1:0] w);
    return ((w[7:0] | 8'h01) == 8'hFF) && (w[27:26] == STATUS_GOOD);
  endfunction

  function automatic logic [15:0] fault_field(input logic [WORD_W-1:0] w);
    return w[20:5];
  endfunction

endpackage

// File: rtl/gis_timer.sv
module gis_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/gis_step_table.sv
module gis_step_table
  import gis_pkg::*;
#(
  parameter int CW        = 8,
  parameter int LONG_CYC  = 100,
  parameter int SHORT_CYC = 50
) (
  input  logic [2:0]        cur_step,
  input  logic [2:0]        plan_step,
  output logic [WORD_W-1:0] cur_word,
  output check_t            cur_kind,
  output logic              cur_last,
  output logic [CW-1:0]     plan_gap
);
  localparam logic [CW-1:0] GAP_LONG  = CW'(LONG_CYC);
  localparam logic [CW-1:0] GAP_SHORT = CW'(SHORT_CYC);

  always_comb begin
    cur_word = sensor_cmd(1'b0);
    cur_kind = CK_IGNORE;
    cur_last = 1'b0;
    case (cur_step)
      3'd0: begin
        cur_word = sensor_cmd(1'b1);
        cur_kind = CK_FIRST;
      end
      3'd1: cur_kind = CK_IGNORE;
      3'd2: cur_kind = CK_STATUS;
      3'd3: cur_kind = CK_STATUS;
      3'd4: begin
        cur_word = read_cmd(FAULT_ADDR);
        cur_kind = CK_FAULT;
        cur_last = 1'b1;
      end
      default: cur_last = 1'b1;
    endcase
  end

  always_comb begin
    case (plan_step)
      3'd0:       plan_gap = GAP_LONG;
      3'd1, 3'd2: plan_gap = GAP_SHORT;
      default:    plan_gap = '0;
    endcase
  end
endmodule

// File: rtl/gis_reply_eval.sv
module gis_reply_eval
  import gis_pkg::*;
(
  input  check_t            kind,
  input  logic [WORD_W-1:0] rsp_word,
  output logic              warn_hit,
  output logic              fail_hit,
  output logic [15:0]       fault_bits
);
  assign fault_bits = fault_field(rsp_word);

  always_comb begin
    warn_hit = 1'b0;
    fail_hit = 1'b0;
    case (kind)
      CK_FIRST:  warn_hit = (rsp_word != FIRST_GOOD);
      CK_STATUS: fail_hit = !reply_ok(rsp_word);
      CK_FAULT:  fail_hit = |(fault_bits & FAULT_MASK);
      default:   ;
    endcase
  end
endmodule

// File: rtl/gyro_init_seq.sv
module gyro_init_seq
  import gis_pkg::*;
#(
  parameter int CLK_KHZ  = 50000,
  parameter int LONG_MS  = 100,
  parameter int SHORT_MS = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cmd_valid,
  output logic [31:0] cmd_word,
  input  logic        cmd_ready,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_word,
  output logic        hold_off,
  output logic        done,
  output logic        warn,
  output logic        err,
  output logic [2:0]  fail_step,
  output logic [15:0] fault_word
);
  localparam int LONG_CYC  = CLK_KHZ * LONG_MS;
  localparam int SHORT_CYC = CLK_KHZ * SHORT_MS;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  phase_t        phase;
  logic [2:0]    step;
  logic [2:0]    plan_step;
  logic [31:0]   cur_word;
  check_t        cur_kind;
  logic          cur_last;
  logic [CW-1:0] plan_gap;
  logic          tmr_zero;
  logic          warn_hit;
  logic          fail_hit;
  logic [15:0]   fault_bits;

  // Named events used by the FSM and visible to the bound checker.
  logic evt_take;
  logic evt_advance;
  logic evt_fire;

  assign evt_take    = (phase == PH_RESP) && rsp_valid && !start;
  assign evt_advance = evt_take && !fail_hit && !cur_last;
  assign evt_fire    = (phase == PH_SEND) && cmd_ready && !start;
  assign plan_step   = start ? 3'd0 : (step + 3'd1);

  gis_step_table #(
    .CW(CW), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)
  ) u_table (
    .cur_step (step),
    .plan_step(plan_step),
    .cur_word (cur_word),
    .cur_kind (cur_kind),
    .cur_last (cur_last),
    .plan_gap (plan_gap)
  );

  gis_reply_eval u_eval (
    .kind      (cur_kind),
    .rsp_word  (rsp_word),
    .warn_hit  (warn_hit),
    .fail_hit  (fail_hit),
    .fault_bits(fault_bits)
  );

  gis_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start || evt_advance),
    .load_val(plan_gap - 1'b1),
    .dec     (phase == PH_WAIT),
    .zero    (tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      step       <= '0;
      done       <= 1'b0;
      warn       <= 1'b0;
      err        <= 1'b0;
      fail_step  <= '0;
      fault_word <= '0;
    end else if (start) begin
      step       <= '0;
      done       <= 1'b0;
      warn       <= 1'b0;
      err        <= 1'b0;
      fail_step  <= '0;
      fault_word <= '0;
      phase      <= (plan_gap == '0) ? PH_SEND : PH_WAIT;
    end else begin
      case (phase)
        PH_WAIT: if (tmr_zero) phase <= PH_SEND;
        PH_SEND: if (evt_fire) phase <= PH_RESP;
        PH_RESP: begin
          if (evt_take) begin
            if (cur_kind == CK_FAULT) fault_word <= fault_bits;
            if (warn_hit) warn <= 1'b1;
            if (fail_hit) begin
              phase     <= PH_FAIL;
              err       <= 1'b1;
              done      <= 1'b1;
              fail_step <= step + 3'd1;
            end else if (cur_last) begin
              phase <= PH_DONE;
              done  <= 1'b1;
            end else begin
              step  <= step + 3'd1;
              phase <= (plan_gap == '0) ? PH_SEND : PH_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign cmd_valid = (phase == PH_SEND);
  assign cmd_word  = cur_word;
  assign hold_off  = (phase != PH_DONE);
endmodule

// File: rtl/gis_checker.sv
module gis_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_word,
  input logic        hold_off,
  input logic        done,
  input logic        warn,
  input logic        err,
  input logic [2:0]  fail_step
);
  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !start) |=> (cmd_valid && $stable(cmd_word)));

  assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> (err && !cmd_valid));

  assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && hold_off));

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !warn && !err && fail_step == 3'd0));

  assert_ok_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (!hold_off && fail_step == 3'd0));

  assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (fail_step >= 3'd3 && fail_step <= 3'd5));

  assert_warn_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warn && !start) |=> warn);
endmodule

bind gyro_init_seq gis_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_word (cmd_word),
  .hold_off (hold_off),
  .done     (done),
  .warn     (warn),
  .err      (err),
  .fail_step(fail_step)
);

// File: tb/gyro_init_seq_tb.sv
module gyro_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 1;
  localparam int LONG  = KHZ * 100;
  localparam int SHORT = KHZ * 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_valid;
  logic [31:0] cmd_word;
  logic        cmd_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_word = 32'h0;
  logic        hold_off, done, warn, err;
  logic [2:0]  fail_step;
  logic [15:0] fault_word;
  logic [31:0] cyc = 32'h0;
  int nvec = 0;
  int nbad = 0;
  bit finished = 1'b0;

  gyro_init_seq #(.CLK_KHZ(KHZ), .LONG_MS(100), .SHORT_MS(50)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .hold_off(hold_off), .done(done), .warn(warn), .err(err),
    .fail_step(fail_step), .fault_word(fault_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit b_reply_good(input logic [31:0] w);
    return ((w & 32'hFE) == 32'hFE) && (((w >> 26) & 32'h3) == 32'h2);
  endfunction

  function automatic logic [31:0] b_with_parity(input logic [31:0] w);
    return ($countones(w) % 2 == 0) ? (w | 32'h1) : w;
  endfunction

  function automatic logic [31:0] b_fault_cmd();
    return b_with_parity((32'h1 << 31) | (32'd10 << 17));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] at, input string tag,
                       input logic [31:0] rsp, output logic [31:0] t_rsp);
    int guard = 0;
    int stall;
    int lat;
    while (!cmd_valid && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    check(cmd_valid && cyc == at, {tag, " command timing"}, cyc, at);
    check(cmd_word == w, {tag, " command word"}, cmd_word, w);
    stall = $urandom_range(0, 2);
    repeat (stall) @(negedge clk);
    if (stall > 0) check(cmd_valid && cmd_word == w, "R11 word held", cmd_word, w);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    lat = $urandom_range(0, 2);
    repeat (lat) @(negedge clk);
    rsp_word  = rsp;
    rsp_valid = 1'b1;
    t_rsp     = cyc;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_word  = $urandom;
  endtask

  task automatic expect_fail(input logic [2:0] code, input string tag);
    bit quiet = 1'b1;
    check(err && done, {tag, " err and done"}, {30'h0, err, done}, 32'h3);
    check(fail_step == code, {tag, " fail_step"}, {29'h0, fail_step}, {29'h0, code});
    check(hold_off, "R9 hold_off after error", {31'h0, hold_off}, 32'h1);
    repeat (40) begin
      @(negedge clk);
      if (cmd_valid) quiet = 1'b0;
    end
    check(quiet, "R9 no command after error", {31'h0, quiet}, 32'h1);
  endtask

  task automatic run_seq(input logic [31:0] first, input logic [31:0] r2, input logic [31:0] r3,
                         input logic [31:0] r4, input logic [15:0] flt);
    logic [31:0] t;
    logic [31:0] plain;
    bit exp_warn;
    plain = b_with_parity(32'h1 << 29);
    exp_warn = (first != 32'h1);
    @(negedge clk);
    start = 1'b1;
    t = cyc;
    @(negedge clk);
    start = 1'b0;
    check(!done && !warn && !err && fail_step == 0 && fault_word == 0,
          "R10 status cleared", {done, warn, err, fail_step, fault_word}, 32'h0);
    issue(b_with_parity((32'h1 << 29) | 32'h2), t + 1 + LONG, "R2", first, t);
    check(warn == exp_warn, "R3 warn after first reply", {31'h0, warn}, {31'h0, exp_warn});
    issue(plain, t + 1 + SHORT, "R4", r2, t);
    issue(plain, t + 1 + SHORT, "R5", r3, t);
    if (!b_reply_good(r3)) begin
      expect_fail(3'd3, "R5");
      return;
    end
    issue(plain, t + 1, "R6", r4, t);
    if (!b_reply_good(r4)) begin
      expect_fail(3'd4, "R6");
      return;
    end
    issue(b_fault_cmd(), t + 1, "R7", {11'h5A5, flt, 5'h1B}, t);
    check(fault_word == flt, "R7 fault field", {16'h0, fault_word}, {16'h0, flt});
    if ((flt & 16'h0FFF) != 0) begin
      expect_fail(3'd5, "R7");
      return;
    end
    check(done && !err && fail_step == 0, "R8 success status",
          {28'h0, done, err, fail_step[1:0]}, 32'h8);
    check(!hold_off, "R8 hold_off released", {31'h0, hold_off}, 32'h0);
    check(warn == exp_warn, "R3 warn at end", {31'h0, warn}, {31'h0, exp_warn});
  endtask

  function automatic logic [31:0] mk_status(input bit good);
    logic [31:0] w;
    w = $urandom;
    w[27:26] = 2'b10;
    w[7:1] = 7'h7F;
    if (!good) begin
      if ($urandom_range(0, 1) == 0) w[27:26] = 2'($urandom_range(0, 1)) | 2'b01;
      else w[$urandom_range(1, 7)] = 1'b0;
    end
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    bit quiet;
    logic [31:0] t;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid && !done && !warn && !err && hold_off && fail_step == 0 && fault_word == 0,
          "R1 reset state", {cmd_valid, done, warn, err, hold_off}, 32'h1);
    quiet = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (cmd_valid) quiet = 1'b0;
    end
    check(quiet, "R1 idle without start", {31'h0, quiet}, 32'h1);

    // Directed cases
    run_seq(32'h1, 32'hFFFF_FFFF, 32'h0BFF_FFFF & 32'hFBFF_FFFF, 32'h0800_00FF, 16'h0000);
    run_seq(32'hDEAD_BEEF, 32'h0, 32'h0800_00FE, 32'h0800_00FF, 16'h0000);
    run_seq(32'h1, 32'h1234, 32'h0400_00FF, 32'h0800_00FF, 16'h0000);
    run_seq(32'h1, 32'h1234, 32'h0800_007F, 32'h0800_00FF, 16'h0000);
    run_seq(32'h1, 32'h0, 32'h0800_00FF, 32'h0C00_00FF, 16'h0000);
    run_seq(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 16'h0800);
    run_seq(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 16'hF000);

    // Restart in the middle of the handshake
    @(negedge clk);
    start = 1'b1;
    t = cyc;
    @(negedge clk);
    start = 1'b0;
    issue(32'h2000_0003, t + 1 + LONG, "R2 restart", 32'h5, t);
    check(warn, "R3 warn before restart", {31'h0, warn}, 32'h1);
    repeat (10) @(negedge clk);
    run_seq(32'h1, 32'h0, 32'h0800_00FF, 32'h0800_00FF, 16'h0000);

    // Random replies
    for (int i = 0; i < 14; i++) begin
      logic [31:0] f;
      logic [15:0] flt;
      f = ($urandom_range(0, 1) == 0) ? 32'h1 : $urandom;
      flt = ($urandom_range(0, 2) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
      run_seq(f, $urandom, mk_status($urandom_range(0, 3) != 0),
              mk_status($urandom_range(0, 3) != 0), flt);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule